// File: doc/BRIEF.md
# Conditional branch and jump unit

This unit decides whether a conditional branch or a relative jump is taken, and it keeps the two 16-bit address registers that carry out the decision: the instruction address (`instAddr`) and an alternate address (`altAddr`). During the Q-code fetch cycle it compares a six-bit condition mask from the Q code with the condition flags. One mode bit picks the rule. In one mode the branch goes when any masked condition is present. In the other it goes when every masked condition is absent.

For a branch, the two target bytes are fetched into the alternate register, high byte first. A met branch condition does not change the instruction address at once. It sets a pending-swap latch, and the two registers trade contents when the op-end strobe arrives. For a jump, the control byte fetched in the third instruction cycle is added to the address of the next sequential instruction, but only if the condition was met.

A sequencer outside this block supplies one cycle strobe at a time and the storage data byte. Every fetch strobe also steps the instruction address past the byte that was read.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset, `instAddr` and `altAddr` are 0, and `swapPending` and `condMet` are low.
- R2: When `qCode[0]` is 1 and `qCycle` is sampled, `condMet` on the next cycle is 1 if at least one bit of (mask AND `condFlags`) is set, and 0 otherwise.
- R3: When `qCode[0]` is 0, `condMet` on the next cycle is 1 only when (mask AND `condFlags`) is zero. This includes the case of an all-zero mask, which counts as met.
- R4: Mask bit `qCode[k+2]` tests `condFlags[k]` for k = 0..5. Counting from the top: equal = `condFlags[5]`, low = [4], high = [3], decimal overflow = [2], test false = [1], binary overflow = [0]. `qCode[1]` has no effect.
- R5: Each of `opCycle`, `qCycle`, `hiCycle`, `loCycle` and `ctlCycle` advances the fetch position. `opCycle` and `qCycle` add 1 to `instAddr` (modulo 2^16).
- R6: `hiCycle` writes `dataByte` into `altAddr[15:8]`. `loCycle` writes it into `altAddr[7:0]`. Both add 1 to `instAddr`.
- R7: A `qCycle` with `isJump` = 0 whose condition is met sets `swapPending` on the next cycle. `swapPending` is set only in that case. A jump never sets it.
- R8: An `opEnd` while `swapPending` is high swaps `instAddr` and `altAddr` and clears `swapPending`. An `opEnd` while `swapPending` is low changes nothing.
- R9: `ctlCycle` sets `instAddr` to `instAddr + 1 + dataByte` when `condMet` is high, and to `instAddr + 1` otherwise. The byte is zero-extended and the sum wraps modulo 2^16.
- R10: `addrLoad` writes `loadAddr` into `instAddr`. It has priority over every other strobe, and all other strobes are ignored in that cycle. Apart from `addrLoad`, at most one strobe is high per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | Load `loadAddr` into the instruction address |
| loadAddr | input | 16 | Value for `addrLoad` |
| opCycle | input | 1 | Op-code fetch cycle |
| qCycle | input | 1 | Q-code fetch cycle; the condition test is made here |
| hiCycle | input | 1 | Branch target high byte fetch |
| loCycle | input | 1 | Branch target low byte fetch |
| ctlCycle | input | 1 | Jump control byte fetch |
| opEnd | input | 1 | End of the current operation |
| isJump | input | 1 | 1 = jump instruction, 0 = branch instruction |
| qCode | input | 8 | Q code: bit 0 selects the mode, bits 7..2 are the mask |
| condFlags | input | 6 | Condition register flags |
| dataByte | input | 8 | Byte read from storage |
| instAddr | output | 16 | Instruction address register |
| altAddr | output | 16 | Alternate address register |
| swapPending | output | 1 | Interchange latch |
| condMet | output | 1 | Result of the last condition test |

## Verification
A wrong evaluation of the mask shows up on `condMet` one cycle after `qCycle`. For a branch, the same fault also shows on `swapPending`.

A latch that fails to clear, or that is set by a jump, shows up as an unexpected swap of `instAddr` and `altAddr` on the cycle after the next `opEnd`.

A fault in the address datapath shows up in the register it corrupts on the cycle after the strobe, for example a byte in the wrong half, an offset added when it should not be, or a lost carry on wrap. The bench compares all four outputs after every strobe, so such faults are caught within one cycle.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int NUM_COND = 6;
  localparam int MASK_LSB = 2;
  localparam int Q_W      = MASK_LSB + NUM_COND;

  // Strobes from control to the address datapath
  typedef struct packed {
    logic loadIar;
    logic incIar;
    logic loadHi;
    logic loadLo;
    logic addOffset;
    logic swap;
  } dpCtl_t;
endpackage

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval #(
  parameter int NUM_COND = cbu_pkg::NUM_COND
) (
  input  logic                presentMode,
  input  logic [NUM_COND-1:0] mask,
  input  logic [NUM_COND-1:0] condFlags,
  output logic                met
);
  logic [NUM_COND-1:0] hits;

  genvar g;
  generate
    for (g = 0; g < NUM_COND; g++) begin : gHit
      assign hits[g] = mask[g] & condFlags[g];
    end
  endgenerate

  // any-present when presentMode, otherwise all-absent
  always_comb begin
    if (presentMode) met = |hits;
    else             met = ~|hits;
  end
endmodule

// File: rtl/cbu_ctrl.sv
module cbu_ctrl (
  input  logic            clk,
  input  logic            rstN,
  input  logic            addrLoad,
  input  logic            opCycle,
  input  logic            qCycle,
  input  logic            hiCycle,
  input  logic            loCycle,
  input  logic            ctlCycle,
  input  logic            opEnd,
  input  logic            isJump,
  input  logic            evalMet,
  output cbu_pkg::dpCtl_t dpCtl,
  output logic            condMet,
  output logic            swapPending
);
  logic condMetQ;
  logic xchgQ;
  logic active;

  assign active = ~addrLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condMetQ <= 1'b0;
      xchgQ    <= 1'b0;
    end else if (active) begin
      if (qCycle) begin
        condMetQ <= evalMet;
        if (!isJump && evalMet) xchgQ <= 1'b1;
      end
      if (opEnd && xchgQ) xchgQ <= 1'b0;
    end
  end

  always_comb begin
    dpCtl.loadIar   = addrLoad;
    dpCtl.incIar    = active & (opCycle | qCycle | hiCycle | loCycle | ctlCycle);
    dpCtl.loadHi    = active & hiCycle;
    dpCtl.loadLo    = active & loCycle;
    dpCtl.addOffset = active & ctlCycle & condMetQ;
    dpCtl.swap      = active & opEnd & xchgQ;
  end

  assign condMet     = condMetQ;
  assign swapPending = xchgQ;
endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath #(
  parameter int ADDR_W = cbu_pkg::ADDR_W,
  parameter int DATA_W = cbu_pkg::DATA_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  cbu_pkg::dpCtl_t dpCtl,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] dataByte,
  output logic [ADDR_W-1:0] instAddr,
  output logic [ADDR_W-1:0] altAddr
);
  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] iarQ;
  logic [ADDR_W-1:0] arrQ;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] nextSeq;

  assign offset  = dpCtl.addOffset ? {{PAD_W{1'b0}}, dataByte} : '0;
  assign nextSeq = iarQ + ADDR_W'(1) + offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iarQ <= '0;
      arrQ <= '0;
    end else if (dpCtl.loadIar) begin
      iarQ <= loadAddr;
    end else if (dpCtl.swap) begin
      iarQ <= arrQ;
      arrQ <= iarQ;
    end else begin
      if (dpCtl.incIar) iarQ <= nextSeq;
      if (dpCtl.loadHi) arrQ[ADDR_W-1 -: DATA_W] <= dataByte;
      if (dpCtl.loadLo) arrQ[DATA_W-1:0]         <= dataByte;
    end
  end

  assign instAddr = iarQ;
  assign altAddr  = arrQ;
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int ADDR_W   = cbu_pkg::ADDR_W,
  parameter int DATA_W   = cbu_pkg::DATA_W,
  parameter int NUM_COND = cbu_pkg::NUM_COND,
  parameter int MASK_LSB = cbu_pkg::MASK_LSB,
  localparam int Q_W     = MASK_LSB + NUM_COND
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                addrLoad,
  input  logic [ADDR_W-1:0]   loadAddr,
  input  logic                opCycle,
  input  logic                qCycle,
  input  logic                hiCycle,
  input  logic                loCycle,
  input  logic                ctlCycle,
  input  logic                opEnd,
  input  logic                isJump,
  input  logic [Q_W-1:0]      qCode,
  input  logic [NUM_COND-1:0] condFlags,
  input  logic [DATA_W-1:0]   dataByte,
  output logic [ADDR_W-1:0]   instAddr,
  output logic [ADDR_W-1:0]   altAddr,
  output logic                swapPending,
  output logic                condMet
);
  cbu_pkg::dpCtl_t dpCtl;
  logic            evalMet;
  logic            unusedQBits;

  // bits between the mode bit and the mask carry no meaning here
  assign unusedQBits = ^qCode[MASK_LSB-1:1];

  cbu_cond_eval #(.NUM_COND(NUM_COND)) u_eval (
    .presentMode (qCode[0]),
    .mask        (qCode[Q_W-1:MASK_LSB]),
    .condFlags   (condFlags),
    .met         (evalMet)
  );

  cbu_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addrLoad    (addrLoad),
    .opCycle     (opCycle),
    .qCycle      (qCycle),
    .hiCycle     (hiCycle),
    .loCycle     (loCycle),
    .ctlCycle    (ctlCycle),
    .opEnd       (opEnd),
    .isJump      (isJump),
    .evalMet     (evalMet),
    .dpCtl       (dpCtl),
    .condMet     (condMet),
    .swapPending (swapPending)
  );

  cbu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .loadAddr (loadAddr),
    .dataByte (dataByte),
    .instAddr (instAddr),
    .altAddr  (altAddr)
  );
endmodule

// File: rtl/cbu_checks.sv
module cbu_checks #(
  parameter int ADDR_W   = cbu_pkg::ADDR_W,
  parameter int DATA_W   = cbu_pkg::DATA_W,
  parameter int NUM_COND = cbu_pkg::NUM_COND,
  parameter int MASK_LSB = cbu_pkg::MASK_LSB,
  localparam int Q_W     = MASK_LSB + NUM_COND
) (
  input logic                clk,
  input logic                rstN,
  input logic                addrLoad,
  input logic [ADDR_W-1:0]   loadAddr,
  input logic                opCycle,
  input logic                qCycle,
  input logic                hiCycle,
  input logic                loCycle,
  input logic                ctlCycle,
  input logic                opEnd,
  input logic                isJump,
  input logic [Q_W-1:0]      qCode,
  input logic [NUM_COND-1:0] condFlags,
  input logic [DATA_W-1:0]   dataByte,
  input logic [ADDR_W-1:0]   instAddr,
  input logic [ADDR_W-1:0]   altAddr,
  input logic                swapPending,
  input logic                condMet
);
  logic anyHit;
  assign anyHit = |(qCode[Q_W-1:MASK_LSB] & condFlags);

  // R2 and R3: result of the test appears one cycle after qCycle
  p_cond_eval_r2: assert property (@(posedge clk) disable iff (!rstN)
    (qCycle && !addrLoad) |=> condMet == ($past(qCode[0]) ? $past(anyHit) : !$past(anyHit)));

  p_seq_inc_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((opCycle || qCycle) && !addrLoad) |=> instAddr == $past(instAddr) + ADDR_W'(1));

  p_hi_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hiCycle && !addrLoad) |=> altAddr[ADDR_W-1 -: DATA_W] == $past(dataByte));

  p_lo_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loCycle && !addrLoad) |=> altAddr[DATA_W-1:0] == $past(dataByte));

  p_latch_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swapPending) |-> $past(qCycle && !isJump && !addrLoad));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opEnd && swapPending && !addrLoad) |=>
      (instAddr == $past(altAddr) && altAddr == $past(instAddr) && !swapPending));

  p_idle_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opEnd && !swapPending && !addrLoad) |=> ($stable(instAddr) && $stable(altAddr)));

  p_jump_add_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCycle && !addrLoad) |=>
      instAddr == $past(instAddr) + ADDR_W'(1) +
                  ($past(condMet) ? {{(ADDR_W-DATA_W){1'b0}}, $past(dataByte)} : ADDR_W'(0)));

  p_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> instAddr == $past(loadAddr));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opCycle, qCycle, hiCycle, loCycle, ctlCycle, opEnd}));
endmodule

bind cond_branch_unit cbu_checks u_checks (.*);

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        addrLoad, opCycle, qCycle, hiCycle, loCycle, ctlCycle, opEnd, isJump;
  logic [15:0] loadAddr;
  logic [7:0]  qCode;
  logic [5:0]  condFlags;
  logic [7:0]  dataByte;
  logic [15:0] instAddr, altAddr;
  logic        swapPending, condMet;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mIar, mArr;
  logic        mPend, mMet;

  always #5 clk = ~clk;

  cond_branch_unit u_dut (.*);

  function automatic logic evalCond(logic [7:0] q, logic [5:0] f);
    logic hit = 1'b0;
    for (int k = 0; k < 6; k++) if (q[k+2] && f[k]) hit = 1'b1;
    return q[0] ? hit : !hit;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "instAddr", instAddr, mIar);
    chk(tag, "altAddr", altAddr, mArr);
    chk(tag, "swapPending", {15'd0, swapPending}, {15'd0, mPend});
    chk(tag, "condMet", {15'd0, condMet}, {15'd0, mMet});
  endtask

  // op: 0 idle,1 op,2 q,3 hi,4 lo,5 ctl,6 opEnd,7 load
  task automatic step(int op, logic [7:0] q, logic [5:0] f, logic [7:0] d,
                      logic j, logic [15:0] la, string tag);
    @(negedge clk);
    addrLoad = (op == 7); opCycle = (op == 1); qCycle = (op == 2);
    hiCycle = (op == 3); loCycle = (op == 4); ctlCycle = (op == 5); opEnd = (op == 6);
    qCode = q; condFlags = f; dataByte = d; isJump = j; loadAddr = la;
    case (op)
      1: mIar = mIar + 16'd1;
      2: begin
           mMet = evalCond(q, f);
           if (!j && mMet) mPend = 1'b1;
           mIar = mIar + 16'd1;
         end
      3: begin mArr[15:8] = d; mIar = mIar + 16'd1; end
      4: begin mArr[7:0] = d; mIar = mIar + 16'd1; end
      5: mIar = mIar + 16'd1 + (mMet ? {8'd0, d} : 16'd0);
      6: if (mPend) begin
           logic [15:0] t = mIar;
           mIar = mArr; mArr = t; mPend = 1'b0;
         end
      7: mIar = la;
      default: ;
    endcase
    @(posedge clk);
    #2;
    compareAll(tag);
  endtask

  function automatic string tagOf(int op, logic [7:0] q);
    case (op)
      1: return "R5";
      2: return q[0] ? "R2" : "R3";
      3, 4: return "R6";
      5: return "R9";
      6: return "R8";
      7: return "R10";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    rstN = 1'b0;
    {addrLoad, opCycle, qCycle, hiCycle, loCycle, ctlCycle, opEnd, isJump} = '0;
    loadAddr = '0; qCode = '0; condFlags = '0; dataByte = '0;
    mIar = '0; mArr = '0; mPend = 1'b0; mMet = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    compareAll("R1");
    @(negedge clk); rstN = 1'b1;

    // taken branch through to op end (R7, R8)
    step(7, 8'h00, 6'h00, 8'h00, 0, 16'h1000, "R10");
    step(1, 8'h00, 6'h00, 8'h00, 0, 16'h0000, "R5");
    step(2, 8'h81, 6'h20, 8'h00, 0, 16'h0000, "R7");
    step(3, 8'h00, 6'h00, 8'h12, 0, 16'h0000, "R6");
    step(4, 8'h00, 6'h00, 8'h34, 0, 16'h0000, "R6");
    step(6, 8'h00, 6'h00, 8'h00, 0, 16'h0000, "R8");
    step(6, 8'h00, 6'h00, 8'h00, 0, 16'h0000, "R8");
    // zero mask, all-absent mode counts as met (R3)
    step(2, 8'h00, 6'h3F, 8'h00, 1, 16'h0000, "R3");
    // bit 1 has no effect; each mask bit tests its own flag (R4)
    step(2, 8'h02, 6'h3F, 8'h00, 1, 16'h0000, "R4");
    for (int k = 0; k < 6; k++) begin
      step(2, 8'h01 | (8'h04 << k), 6'h01 << k, 8'h00, 1, 16'h0000, "R4");
      step(2, 8'h01 | (8'h04 << k), ~(6'h01 << k), 8'h00, 1, 16'h0000, "R4");
    end
    // jump with wrap (R9), jump never latches (R7)
    step(7, 8'h00, 6'h00, 8'h00, 1, 16'hFFF0, "R10");
    step(2, 8'h05, 6'h01, 8'h00, 1, 16'h0000, "R7");
    step(5, 8'h00, 6'h00, 8'hFF, 1, 16'h0000, "R9");
    step(2, 8'h05, 6'h00, 8'h00, 1, 16'h0000, "R2");
    step(5, 8'h00, 6'h00, 8'h7F, 1, 16'h0000, "R9");
    step(6, 8'h00, 6'h00, 8'h00, 1, 16'h0000, "R8");

    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 7);
      logic [7:0] q = 8'($urandom);
      if ($urandom_range(0, 3) == 0) q[7:2] = 6'h00;
      step(op, q, 6'($urandom), 8'($urandom), 1'($urandom),
           16'($urandom), tagOf(op, q));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule